// File: doc/BRIEF.md
# Left-Justified Serial Audio Receiver

This block takes a stereo audio stream arriving on three pins (serial data, bit clock, channel select) that are all synchronous to the master clock it runs on. It brings every pin into its own clock domain, decides whether the bit clock is supplied on the bit-clock pin or must be produced internally, and assembles MSB-first two's-complement words into fixed 24-bit left and right samples. Each finished sample is presented with a single-cycle strobe.

Operation is organised around two named machines. The clock-mode machine has the states MODE_INT and MODE_EXT. The transition MODE_INT to MODE_EXT (named ENTER_EXT) fires on any edge of the synchronized bit-clock pin. The transition MODE_EXT to MODE_INT (named TIMEOUT) fires at a rising edge of the channel-select pin once a full channel-select period has gone by with no bit-clock edge. The word-capture machine counts bit slots from each channel-select edge. It has the phases SKIP (slot 0), FILL (slots 1 to 24) and DISCARD (later slots). A downstream mute controller uses the mode flag and the one-cycle mode-change pulse.

When no external bit clock is present, the internal bit clock runs at a rate set by the `ratio_sel` code. Its first rising edge comes half a bit period after each channel-select edge.

Top module: `lj_audio_rx`

## Requirements
- R1: While reset is low and in the first cycle after it, both words read zero, both strobes and `mode_flip` are low, and `ext_clk_mode` is 0 (internal mode).
- R2: Data is taken on rising edges of the active bit clock, MSB first. The first rising edge after any channel-select transition (slot 0) is skipped, and slot 1 carries bit 23 of the word.
- R3: A half with `lrclk_in` low fills the left word, and a half with it high fills the right word. A word is published, with a one-cycle strobe, when the channel-select edge that ends its half is detected.
- R4: If a half carries fewer than 24 data slots, the unfilled low bits of the word are zero.
- R5: Data slots beyond the 24th in a half have no effect on the word.
- R6: Any bit-clock pin edge in internal mode switches to external mode (`ext_clk_mode`=1). From then on, bit-clock pin rising edges define the slots.
- R7: In external mode, a rising channel-select edge with no bit-clock edge since the previous rising channel-select edge returns the block to internal mode.
- R8: The internal bit-clock period is 8 master-clock cycles for `ratio_sel`=0 (256×fs, 16 slots per half) and for `ratio_sel`=1 (384×fs, 24 slots per half), and 16 cycles for `ratio_sel`=2 or 3 (512×fs, 16 slots per half).
- R9: `left_strobe` and `right_strobe` are never high together, and each stays high for one cycle only.
- R10: `mode_flip` is high for exactly the cycles in which `ext_clk_mode` differs from its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic and all pins are synchronous to it |
| rst_n | input | 1 | Active-low reset |
| sclk_in | input | 1 | External bit-clock pin |
| lrclk_in | input | 1 | Channel-select pin (low = left, high = right) |
| sdata_in | input | 1 | Serial data pin |
| ratio_sel | input | 2 | Master-clock to sample-rate ratio code: 0=256, 1=384, 2/3=512 |
| left_word | output | 24 | Last completed left sample |
| left_strobe | output | 1 | One-cycle pulse when `left_word` updates |
| right_word | output | 24 | Last completed right sample |
| right_strobe | output | 1 | One-cycle pulse when `right_word` updates |
| ext_clk_mode | output | 1 | 1 = external bit clock in use, 0 = internal |
| mode_flip | output | 1 | One-cycle pulse when the clock mode changes |

## Verification
The bench builds the block with its default parameters: a 24-bit word, two synchronizer stages, and ratios 256, 384 and 512 with 32 and 48 slots per frame. These give internal dividers of 8 and 16 cycles, so every internal-mode rate and its slot count can be reached in a few hundred cycles. With the 24-bit word, external frames of 9, 17, 25, 26 and 33 slots per half land on both sides of the word width, which exercises zero fill and truncation. The external bit clock runs at 8 master-clock cycles per bit, so the synchronizer delay never reorders data against its bit-clock edge.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

    typedef enum logic [0:0] {
        MODE_INT = 1'b0,
        MODE_EXT = 1'b1
    } clk_mode_e;

    typedef enum logic [1:0] {
        PH_SKIP    = 2'd0,
        PH_FILL    = 2'd1,
        PH_DISCARD = 2'd2
    } slot_phase_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

endpackage

// File: rtl/lj_pin_sync.sv
module lj_pin_sync
    import lj_rx_pkg::*;
#(
    parameter int N_PINS = 3,
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PINS-1:0]      pins,
    output pin_ev_t [N_PINS-1:0]   ev
);

    localparam int CHAIN = STAGES + 1;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], pins[p]};
            end
        end

        assign ev[p].level = chain_q[STAGES-1];
        assign ev[p].rise  =  chain_q[STAGES-1] & ~chain_q[STAGES];
        assign ev[p].fall  = ~chain_q[STAGES-1] &  chain_q[STAGES];
    end

endmodule

// File: rtl/lj_mode_fsm.sv
module lj_mode_fsm
    import lj_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_edge,
    input  logic lr_rise,
    output logic ext_mode,
    output logic mode_flip
);

    clk_mode_e state_q, state_d;
    logic      seen_q;
    logic      armed_q;
    logic      enter_ext;
    logic      timeout;

    assign enter_ext = bclk_edge;
    assign timeout   = lr_rise && armed_q && !seen_q && !bclk_edge;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_INT: if (enter_ext) state_d = MODE_EXT;
            MODE_EXT: if (timeout)   state_d = MODE_INT;
            default:                 state_d = MODE_INT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_INT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_flip <= 1'b0;
            seen_q    <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            mode_flip <= (state_d != state_q);
            if (lr_rise) begin
                seen_q <= bclk_edge;
            end else if (bclk_edge) begin
                seen_q <= 1'b1;
            end
            if (state_d != state_q) begin
                armed_q <= 1'b0;
            end else if (lr_rise) begin
                armed_q <= 1'b1;
            end
        end
    end

    assign ext_mode = (state_q == MODE_EXT);

endmodule

// File: rtl/lj_int_bclk.sv
module lj_int_bclk #(
    parameter int RATIO_A = 256,
    parameter int RATIO_B = 384,
    parameter int RATIO_C = 512,
    parameter int SLOTS_A = 32,
    parameter int SLOTS_B = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lr_edge,
    input  logic [1:0] ratio_sel,
    output logic       tick
);

    localparam int DIV_A = RATIO_A / SLOTS_A;
    localparam int DIV_B = RATIO_B / SLOTS_B;
    localparam int DIV_C = RATIO_C / SLOTS_A;
    localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                              : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
    localparam int CW = $clog2(DIV_MAX + 1);

    logic [CW-1:0] div;
    logic [CW-1:0] cnt_q;

    always_comb begin
        unique case (ratio_sel)
            2'd0:    div = CW'(DIV_A);
            2'd1:    div = CW'(DIV_B);
            default: div = CW'(DIV_C);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (lr_edge) begin
                cnt_q <= '0;
            end else begin
                if (cnt_q == (div >> 1) - CW'(1)) tick <= 1'b1;
                if (cnt_q >= div - CW'(1)) cnt_q <= '0;
                else                       cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/lj_word_capture.sv
module lj_word_capture
    import lj_rx_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              sdata,
    input  logic              lr_rise,
    input  logic              lr_fall,
    output logic [WORD_W-1:0] left_word,
    output logic              left_strobe,
    output logic [WORD_W-1:0] right_word,
    output logic              right_strobe
);

    localparam int SW = $clog2(WORD_W + 2);

    logic [SW-1:0]     slot_q;
    logic [WORD_W-1:0] word_q;
    slot_phase_e       phase;

    always_comb begin
        if (slot_q == '0)                     phase = PH_SKIP;
        else if (slot_q <= SW'(WORD_W))       phase = PH_FILL;
        else                                  phase = PH_DISCARD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            word_q <= '0;
        end else if (lr_rise || lr_fall) begin
            slot_q <= '0;
            word_q <= '0;
        end else if (bit_tick) begin
            unique case (phase)
                PH_SKIP: slot_q <= slot_q + SW'(1);
                PH_FILL: begin
                    word_q[WORD_W - int'(slot_q)] <= sdata;
                    slot_q <= slot_q + SW'(1);
                end
                PH_DISCARD: slot_q <= slot_q;
                default:    slot_q <= slot_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_word    <= '0;
            right_word   <= '0;
            left_strobe  <= 1'b0;
            right_strobe <= 1'b0;
        end else begin
            left_strobe  <= lr_rise;
            right_strobe <= lr_fall;
            if (lr_rise) left_word  <= word_q;
            if (lr_fall) right_word <= word_q;
        end
    end

endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx
    import lj_rx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int RATIO_A     = 256,
    parameter int RATIO_B     = 384,
    parameter int RATIO_C     = 512,
    parameter int SLOTS_A     = 32,
    parameter int SLOTS_B     = 48
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              lrclk_in,
    input  logic              sdata_in,
    input  logic [1:0]        ratio_sel,
    output logic [WORD_W-1:0] left_word,
    output logic              left_strobe,
    output logic [WORD_W-1:0] right_word,
    output logic              right_strobe,
    output logic              ext_clk_mode,
    output logic              mode_flip
);

    localparam int PIN_SCLK = 0;
    localparam int PIN_LR   = 1;
    localparam int PIN_DATA = 2;
    localparam int N_PINS   = 3;

    pin_ev_t [N_PINS-1:0] ev;
    logic                 int_tick;
    logic                 bit_tick;

    lj_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .pins  ({sdata_in, lrclk_in, sclk_in}),
        .ev    (ev)
    );

    lj_mode_fsm u_mode (
        .clk       (mclk),
        .rst_n     (rst_n),
        .bclk_edge (ev[PIN_SCLK].rise | ev[PIN_SCLK].fall),
        .lr_rise   (ev[PIN_LR].rise),
        .ext_mode  (ext_clk_mode),
        .mode_flip (mode_flip)
    );

    lj_int_bclk #(
        .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C),
        .SLOTS_A(SLOTS_A), .SLOTS_B(SLOTS_B)
    ) u_bclk (
        .clk       (mclk),
        .rst_n     (rst_n),
        .lr_edge   (ev[PIN_LR].rise | ev[PIN_LR].fall),
        .ratio_sel (ratio_sel),
        .tick      (int_tick)
    );

    assign bit_tick = ext_clk_mode ? ev[PIN_SCLK].rise : int_tick;

    lj_word_capture #(.WORD_W(WORD_W)) u_cap (
        .clk          (mclk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .sdata        (ev[PIN_DATA].level),
        .lr_rise      (ev[PIN_LR].rise),
        .lr_fall      (ev[PIN_LR].fall),
        .left_word    (left_word),
        .left_strobe  (left_strobe),
        .right_word   (right_word),
        .right_strobe (right_strobe)
    );

endmodule

// File: rtl/lj_rx_chk.sv
module lj_rx_chk #(
    parameter int WORD_W = 24
) (
    input logic              mclk,
    input logic              rst_n,
    input logic [WORD_W-1:0] left_word,
    input logic              left_strobe,
    input logic [WORD_W-1:0] right_word,
    input logic              right_strobe,
    input logic              ext_clk_mode,
    input logic              mode_flip
);

    // R9
    strobe_excl_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !(left_strobe && right_strobe));

    // R9
    left_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        left_strobe |=> !left_strobe);

    // R9
    right_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        right_strobe |=> !right_strobe);

    // R3
    left_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !left_strobe |-> $stable(left_word));

    // R3
    right_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !right_strobe |-> $stable(right_word));

    // R10
    flip_follows_mode_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (ext_clk_mode != $past(ext_clk_mode)) |-> mode_flip);

    // R10
    flip_only_on_change_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        mode_flip |-> (ext_clk_mode != $past(ext_clk_mode)));

endmodule

bind lj_audio_rx lj_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .mclk         (mclk),
    .rst_n        (rst_n),
    .left_word    (left_word),
    .left_strobe  (left_strobe),
    .right_word   (right_word),
    .right_strobe (right_strobe),
    .ext_clk_mode (ext_clk_mode),
    .mode_flip    (mode_flip)
);

// File: tb/tb_lj_audio_rx.sv
module tb_lj_audio_rx;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {slots per half (6b), left sample (32b, MSB aligned), right sample (32b)}
    localparam logic [69:0] VEC [NVEC] = '{
        {6'd25, 32'hA5C3_9E71, 32'h1234_5678},
        {6'd17, 32'hFEDC_BA98, 32'h8001_7FFE},
        {6'd33, 32'h7BCD_EF13, 32'hC0FF_EE55},
        {6'd9,  32'hD200_0000, 32'h3C00_0000},
        {6'd26, 32'h5555_AAAA, 32'h9696_6969}
    };

    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        lrclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [1:0]  ratio_sel = 2'd1;
    logic [23:0] left_word, right_word;
    logic        left_strobe, right_strobe, ext_clk_mode, mode_flip;

    int checks = 0;
    int failures = 0;
    int flips = 0;
    int both_hi = 0;
    logic [23:0] last_left = '0;
    logic [23:0] last_right = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) mclk = ~mclk;

    lj_audio_rx dut (
        .mclk(mclk), .rst_n(rst_n), .sclk_in(sclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .ratio_sel(ratio_sel),
        .left_word(left_word), .left_strobe(left_strobe),
        .right_word(right_word), .right_strobe(right_strobe),
        .ext_clk_mode(ext_clk_mode), .mode_flip(mode_flip)
    );

    always @(negedge mclk) begin
        if (rst_n) begin
            if (left_strobe)  last_left  <= left_word;
            if (right_strobe) last_right <= right_word;
            if (mode_flip)    flips <= flips + 1;
            if (left_strobe && right_strobe) both_hi <= both_hi + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(logic [31:0] s, int data_slots);
        int k;
        logic [23:0] m;
        k = (data_slots > 24) ? 24 : data_slots;
        m = ~(24'hFF_FFFF >> k);
        return s[31:8] & m;
    endfunction

    function automatic logic slot_bit(logic [31:0] s, int slot);
        if (slot == 0 || slot > 32) return 1'b0;
        return s[32 - slot];
    endfunction

    // one bit slot: external (bit clock driven, 8 cycles) or internal (div cycles)
    task automatic drive_slot(logic b, bit ext, int div);
        sdata_in = b;
        if (ext) begin
            repeat (4) @(negedge mclk);
            sclk_in = 1'b1;
            repeat (4) @(negedge mclk);
            sclk_in = 1'b0;
        end else begin
            repeat (div) @(negedge mclk);
        end
    endtask

    task automatic drive_half(logic lvl, int nslots, logic [31:0] s, bit ext, int div);
        lrclk_in = lvl;
        for (int i = 0; i < nslots; i++) drive_slot(slot_bit(s, i), ext, div);
    endtask

    task automatic frame(int nslots, logic [31:0] l, logic [31:0] r, bit ext, int div);
        drive_half(1'b1, 2, 32'h0, ext, div);
        drive_half(1'b0, nslots, l, ext, div);
        drive_half(1'b1, nslots, r, ext, div);
        drive_half(1'b0, 2, 32'h0, ext, div);
        repeat (6) @(negedge mclk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge mclk);
        // R1: reset state
        check("R1 left_word", 32'(left_word), 32'h0);
        check("R1 right_word", 32'(right_word), 32'h0);
        check("R1 ext_clk_mode", 32'(ext_clk_mode), 32'h0);
        check("R1 strobes", 32'({left_strobe, right_strobe, mode_flip}), 32'h0);
        rst_n = 1'b1;
        @(negedge mclk);
        check("R1 after release", 32'({left_strobe, right_strobe, mode_flip, ext_clk_mode}), 32'h0);

        // R8: internal clock, ratio 384 -> 24 slots, 23 data bits
        ratio_sel = 2'd1;
        frame(24, 32'hC3A5_5A3C, 32'h0F1E_2D3B, 1'b0, 8);
        check("R8 R2 int384 left", 32'(last_left), 32'(exp_word(32'hC3A5_5A3C, 23)));
        check("R8 R3 int384 right", 32'(last_right), 32'(exp_word(32'h0F1E_2D3B, 23)));
        // R8: ratio 256 -> 16 slots at 8 cycles
        ratio_sel = 2'd0;
        frame(16, 32'h9ABC_0000, 32'h4321_0000, 1'b0, 8);
        check("R8 int256 left", 32'(last_left), 32'(exp_word(32'h9ABC_0000, 15)));
        check("R8 int256 right", 32'(last_right), 32'(exp_word(32'h4321_0000, 15)));
        // R8: ratio 512 -> 16 slots at 16 cycles
        ratio_sel = 2'd2;
        frame(16, 32'hE7F1_0000, 32'h2B6D_0000, 1'b0, 16);
        check("R8 int512 left", 32'(last_left), 32'(exp_word(32'hE7F1_0000, 15)));
        check("R8 int512 right", 32'(last_right), 32'(exp_word(32'h2B6D_0000, 15)));
        check("R6 stays internal without bit clock", 32'(ext_clk_mode), 32'h0);

        // R6: bit-clock activity switches to external mode
        ratio_sel = 2'd1;
        frame(25, 32'h8765_4321, 32'h1357_9BDF, 1'b1, 8);
        check("R6 ext mode entered", 32'(ext_clk_mode), 32'h1);
        check("R10 one flip", 32'(flips), 32'h1);
        check("R6 first ext left", 32'(last_left), 32'(exp_word(32'h8765_4321, 24)));

        // R2 R3 R4 R5: vector table in external mode
        for (int v = 0; v < NVEC; v++) begin
            int n;
            n = int'(VEC[v][69:64]);
            frame(n, VEC[v][63:32], VEC[v][31:0], 1'b1, 8);
            check((n - 1 < 24) ? "R4 zero fill left" : "R5 R2 truncate left",
                  32'(last_left), 32'(exp_word(VEC[v][63:32], n - 1)));
            check((n - 1 < 24) ? "R4 zero fill right" : "R5 R3 truncate right",
                  32'(last_right), 32'(exp_word(VEC[v][31:0], n - 1)));
        end
        check("R6 still external", 32'(ext_clk_mode), 32'h1);

        // R7: bit clock stops; return to internal after a silent period
        frame(24, 32'h0, 32'h0, 1'b0, 8);
        check("R7 back to internal", 32'(ext_clk_mode), 32'h0);
        check("R10 two flips", 32'(flips), 32'h2);
        frame(24, 32'h6E5D_4C3B, 32'hF00D_BEEF, 1'b0, 8);
        check("R7 internal left after return", 32'(last_left), 32'(exp_word(32'h6E5D_4C3B, 23)));
        check("R7 internal right after return", 32'(last_right), 32'(exp_word(32'hF00D_BEEF, 23)));

        // R9: strobes never overlapped
        check("R9 strobe overlap count", 32'(both_hi), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule